// File: doc/BRIEF.md
# Submission Tally Controller with Permanent Lockout

The block keeps a running score of guess submissions in a small game. A button circuit delivers a single-cycle submit strobe, and a separate matcher supplies a flag saying whether the current guess pair counts as a hit. On each accepted strobe the controller adds one to either a hit tally or a miss tally. Between strobes the guess inputs may change freely without effect.

The two tallies interact. When the miss tally reaches its limit, both tallies return to zero on that same clock edge. This can happen any number of times, and the misses that cause it need not be consecutive. When the hit tally reaches its limit, a stop flag goes high and stays high. From then on every submission is ignored. Only the synchronous power-on reset releases the stop flag.

Top module: `tally_lockout`

## Requirements
- R1: After reset, `stopped_o` is 0 and both `hit_cnt_o` and `miss_cnt_o` are 0.
- R2: With the block not stopped, a clock edge with `submit_i`=1 and `match_i`=1 adds exactly one to `hit_cnt_o`. With `match_i`=0, that edge adds exactly one to `miss_cnt_o`. The new value is visible right after that edge.
- R3: On a clock edge with `submit_i`=0, none of the three outputs changes, whatever `match_i` does.
- R4: The edge that accepts the sixth hit (HIT_LIMIT=6) sets `stopped_o`, and `hit_cnt_o` then reads 6.
- R5: Once `stopped_o` is 1, it stays 1 and both tallies hold their values, whatever the submissions, until reset.
- R6: The edge that accepts the third miss (MISS_LIMIT=3) clears both tallies to 0, so `miss_cnt_o` never reads 3.
- R7: Hits accepted between misses do not clear the miss tally, so three non-consecutive misses still trigger the clear.
- R8: The clear can repeat any number of times. After each clear, six further hits are needed to stop.
- R9: `stopped_o` stays 0 at every cycle before the hit tally reaches its limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| submit_i | input | 1 | Single-cycle submit strobe |
| match_i | input | 1 | 1 when the current guess is a hit |
| stopped_o | output | 1 | Permanent stop flag |
| hit_cnt_o | output | CNT_W | Hit tally |
| miss_cnt_o | output | CNT_W | Miss tally |

## Verification
The bench builds the block with its default parameters: a 3-bit tally, a hit limit of 6 and a miss limit of 3. At these values the lockout takes only six submissions to reach and the clear only three, so a short run can cover several of each. Directed sequences place hits between misses, repeat the clear, and keep submitting after lockout. A long pseudo-random stream of strobes and flags then lands on the limit edges in many different orders.

// File: rtl/tally_pkg.sv
package tally_pkg;

    // Kind of event presented to the tallies on a given cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HIT  = 2'd1,
        EV_MISS = 2'd2
    } tally_ev_e;

    // Decide which tally an accepted strobe goes to; a stopped block accepts nothing
    function automatic tally_ev_e classify(input logic submit,
                                           input logic match,
                                           input logic stopped);
        if (!submit || stopped) return EV_NONE;
        return match ? EV_HIT : EV_MISS;
    endfunction

endpackage

// File: rtl/tally_sat_counter.sv
module tally_sat_counter #(
    parameter int W     = 3,
    parameter int LIMIT = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         reach
);
    localparam logic [W-1:0] TOP  = W'(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    // Asserted on the increment that brings the count to LIMIT
    assign reach = inc && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tally_stop_latch.sv
module tally_stop_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic q
);
    // Set-only: after reset, nothing but rst can clear it
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/tally_lockout.sv
module tally_lockout
    import tally_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int HIT_LIMIT  = 6,
    parameter int MISS_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             submit_i,
    input  logic             match_i,
    output logic             stopped_o,
    output logic [CNT_W-1:0] hit_cnt_o,
    output logic [CNT_W-1:0] miss_cnt_o
);
    tally_ev_e ev;
    logic      hit_reach;
    logic      miss_reach;

    assign ev = classify(submit_i, match_i, stopped_o);

    tally_sat_counter #(.W(CNT_W), .LIMIT(HIT_LIMIT)) i_hit (
        .clk   (clk),
        .rst   (rst),
        .inc   (ev == EV_HIT),
        .clr   (miss_reach),
        .cnt   (hit_cnt_o),
        .reach (hit_reach)
    );

    // The miss counter clears on the edge that reaches its limit
    tally_sat_counter #(.W(CNT_W), .LIMIT(MISS_LIMIT)) i_miss (
        .clk   (clk),
        .rst   (rst),
        .inc   (ev == EV_MISS),
        .clr   (miss_reach),
        .cnt   (miss_cnt_o),
        .reach (miss_reach)
    );

    tally_stop_latch i_stop (
        .clk (clk),
        .rst (rst),
        .set (hit_reach),
        .q   (stopped_o)
    );
endmodule

// File: rtl/tally_lockout_chk.sv
module tally_lockout_chk #(
    parameter int CNT_W      = 3,
    parameter int HIT_LIMIT  = 6,
    parameter int MISS_LIMIT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             submit_i,
    input logic             match_i,
    input logic             stopped_o,
    input logic [CNT_W-1:0] hit_cnt_o,
    input logic [CNT_W-1:0] miss_cnt_o
);
    localparam logic [CNT_W-1:0] HTOP  = CNT_W'(HIT_LIMIT);
    localparam logic [CNT_W-1:0] MLAST = CNT_W'(MISS_LIMIT - 1);

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (submit_i && match_i && !stopped_o && hit_cnt_o != HTOP - 1'b1)
        |=> (hit_cnt_o == $past(hit_cnt_o) + 1'b1)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !submit_i |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o) && $stable(stopped_o))); // R3

    AST_STOP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        stopped_o == (hit_cnt_o == HTOP)); // R4

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        stopped_o |=> (stopped_o && $stable(hit_cnt_o) && $stable(miss_cnt_o))); // R5

    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (submit_i && !match_i && !stopped_o && miss_cnt_o == MLAST)
        |=> (hit_cnt_o == '0 && miss_cnt_o == '0)); // R6

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
        miss_cnt_o <= MLAST); // R6

    AST_HIT_KEEPS_MISS: assert property (@(posedge clk) disable iff (rst)
        (submit_i && match_i) |=> $stable(miss_cnt_o)); // R7

    AST_HIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        hit_cnt_o <= HTOP); // R9
endmodule

bind tally_lockout tally_lockout_chk #(
    .CNT_W(CNT_W), .HIT_LIMIT(HIT_LIMIT), .MISS_LIMIT(MISS_LIMIT)
) i_chk (
    .clk(clk), .rst(rst), .submit_i(submit_i), .match_i(match_i),
    .stopped_o(stopped_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
);

// File: tb/test_tally_lockout.sv
`timescale 1ns/1ps
module test_tally_lockout;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       submit_i = 1'b0;
    logic       match_i = 1'b0;
    logic       stopped_o;
    logic [2:0] hit_cnt_o;
    logic [2:0] miss_cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state
    int  m_hit  = 0;
    int  m_miss = 0;
    bit  m_stop = 0;

    always #4 clk = ~clk;

    tally_lockout i_tally_lockout (
        .clk(clk), .rst(rst), .submit_i(submit_i), .match_i(match_i),
        .stopped_o(stopped_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (int'(hit_cnt_o) != m_hit || int'(miss_cnt_o) != m_miss || stopped_o != m_stop) begin
            fails++;
            $display("FAIL %s: got hit=%0d miss=%0d stop=%0d, expected hit=%0d miss=%0d stop=%0d",
                     tag, hit_cnt_o, miss_cnt_o, stopped_o, m_hit, m_miss, m_stop);
        end
    endtask

    task automatic model_edge(input bit sub, input bit mt);
        if (rst) begin
            m_hit = 0; m_miss = 0; m_stop = 0;
        end else if (sub && !m_stop) begin
            if (mt) begin
                m_hit++;
                if (m_hit == 6) m_stop = 1;
            end else begin
                m_miss++;
                if (m_miss == 3) begin
                    m_miss = 0;
                    m_hit  = 0;
                end
            end
        end
    endtask

    task automatic step(input bit sub, input bit mt, input string tag);
        @(negedge clk);
        submit_i = sub;
        match_i  = mt;
        @(posedge clk);
        model_edge(sub, mt);
        #1;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; submit_i = 1'b0;
        @(posedge clk);
        model_edge(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        compare("R1 reset state");

        // R3: no strobe, flag toggling
        for (int i = 0; i < 6; i++) step(1'b0, i[0], "R3 idle");

        // R2 / R7: hits interleaved with misses
        step(1'b1, 1'b1, "R2 hit");
        step(1'b1, 1'b1, "R2 hit");
        step(1'b1, 1'b0, "R2 miss");
        step(1'b1, 1'b1, "R7 hit between misses");
        step(1'b0, 1'b0, "R3 idle");
        step(1'b1, 1'b0, "R7 second miss");
        step(1'b1, 1'b1, "R7 hit keeps misses");
        // R6: third miss clears both
        step(1'b1, 1'b0, "R6 third miss clears");

        // R8: repeated clears, five hits then three misses
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R8 hits before clear");
            for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8 misses clear");
        end
        // R9: five fresh hits leave it running
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R9 not yet stopped");
        step(1'b1, 1'b1, "R4 sixth hit stops");
        // R5: ignored after stop
        for (int i = 0; i < 4; i++) step(1'b1, i[0], "R5 frozen");
        for (int i = 0; i < 3; i++) step(1'b0, i[0], "R5 frozen idle");

        do_reset();
        compare("R1 reset releases stop");

        // Pseudo-random stream, with periodic resets
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 700 == 699) begin
                do_reset();
                compare("R1 reset in stream");
            end else begin
                step(lfsr[0] & lfsr[3], lfsr[1] | lfsr[5], "R2 random stream");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule